// File: doc/BRIEF.md
# Bus Handover Controller

This block lives inside a processor that normally owns a shared bus, and it decides when an outside device may take that bus over. Three wires carry the exchange: an active-low request coming in, an active-low grant going out, and an active-low acknowledge coming back once the outside device has actually taken the bus. The local processor always yields to a request, but never in the middle of one of its own bus cycles. It waits for the current cycle to end, and only then raises the grant.

The grant is a conditional offer. If the request disappears before any acknowledge has been seen, the grant is dropped and the processor keeps the bus as though nothing had happened. This filters out glitches on the request wire and requests that are withdrawn early. Once the acknowledge arrives, the local bus drivers stay disabled for as long as the acknowledge is held. The bus comes back to the processor when the acknowledge is released. A stall output tells the local bus sequencer not to start new cycles while a handover is pending or the bus is away.

Both the request and the acknowledge are brought into the clock domain through a two-flop synchronizer. Reset is asynchronous on assertion and is released synchronously to the clock.

Top module: `bus_handover_ctrl`

## Requirements
- R1: The request and acknowledge inputs are active low and pass through two synchronizer flops. With the bus idle, a request applied between clock edges makes `stall` rise after the second following rising edge and `grant_n` fall after the third.
- R2: With no local cycle in progress, a request seen by the controller leads to `grant_n` low on the next edge, while `lbus_en` stays high.
- R3: While `cyc_busy` is high, `grant_n` stays high however long the request is held. `grant_n` falls on the first edge at which `cyc_busy` is sampled low while the synchronized request is still present.
- R4: If the request is withdrawn before any acknowledge is seen, whether the controller is waiting for the cycle to end or already granting, it returns to local ownership: `grant_n` goes high, `lbus_en` stays high, and `stall` falls once the withdrawn request has passed the synchronizer.
- R5: When the synchronized acknowledge is seen while the grant is asserted, the next edge drives `grant_n` high and `lbus_en` low.
- R6: While the synchronized acknowledge stays asserted, `lbus_en` stays low and `grant_n` stays high, whatever the request input does.
- R7: When the synchronized acknowledge is released, the next edge returns the bus to local ownership with `lbus_en` high. `stall` is low if no request is present, and a request that is still present starts a new handover.
- R8: `stall` is high whenever the synchronized request is present, the grant is asserted, or the bus is held by the external master.
- R9: While reset is held, and after it is released with idle inputs, `grant_n` is high, `lbus_en` is high and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 1 | Active-low bus request, wired-OR from external masters |
| ack_n | input | 1 | Active-low grant acknowledge from the external master |
| cyc_busy | input | 1 | High while the local sequencer has a bus cycle in progress |
| grant_n | output | 1 | Active-low bus grant |
| lbus_en | output | 1 | High while the local processor may drive the bus |
| stall | output | 1 | High while the local sequencer must not start a new cycle |

## Verification
The assertions assume that the local sequencer honours `stall`. A cycle may continue once stall rises, but no new cycle starts, and `cyc_busy` is low while the bus is away. They also assume that the external master asserts acknowledge only while it sees the grant, and does not move the request between raising the acknowledge and losing `lbus_en`. The random stimulus derives each cycle's inputs from the outputs it has just observed, so that it keeps to these rules: a new cycle starts only when stall is low, acknowledge is raised only under a visible grant, and the request is frozen while an acknowledge is still on its way. Directed sequences then cover the long busy cycle, the early withdrawal, and toggling the request during external ownership.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE_OWNER     = 2'd0,
    ST_WAIT_CYCLE_END = 2'd1,
    ST_GRANTED        = 2'd2,
    ST_EXTERNAL_OWNER = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ack_s,
  input  logic cyc_busy,
  output logic grant,
  output logic lbus_en,
  output logic stall
);
  arb_state_e state_q, state_nxt;
  logic       state_en;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE_OWNER:
        if (req_s) state_nxt = cyc_busy ? ST_WAIT_CYCLE_END : ST_GRANTED;
      ST_WAIT_CYCLE_END:
        if (!req_s)        state_nxt = ST_IDLE_OWNER;
        else if (!cyc_busy) state_nxt = ST_GRANTED;
      ST_GRANTED:
        if (ack_s)       state_nxt = ST_EXTERNAL_OWNER;
        else if (!req_s) state_nxt = ST_IDLE_OWNER;
      ST_EXTERNAL_OWNER:
        if (!ack_s) state_nxt = ST_IDLE_OWNER;
      default: state_nxt = ST_IDLE_OWNER;
    endcase
  end

  assign state_en = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE_OWNER;
    else if (state_en) state_q <= state_nxt;
  end

  assign grant   = (state_q == ST_GRANTED);
  assign lbus_en = (state_q != ST_EXTERNAL_OWNER);
  assign stall   = (state_q != ST_IDLE_OWNER) || req_s;

  // R3: a grant never starts on an edge at which a local cycle was running
  assert_grant_after_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> !$past(cyc_busy));

  // R3: while waiting and the cycle is still busy, no grant follows
  assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_CYCLE_END && cyc_busy) |=> !grant);

  // R4: withdrawn request before acknowledge keeps the bus local
  assert_keep_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !ack_s && !req_s) |=> (!grant && lbus_en));

  assert_wait_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_CYCLE_END && !req_s) |=> (state_q == ST_IDLE_OWNER));

  // R5: acknowledge under grant hands the bus over
  assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && ack_s) |=> (!grant && !lbus_en));

  // R6: held acknowledge keeps the local drivers off
  assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lbus_en && ack_s) |=> (!lbus_en && !grant));

  // R7: released acknowledge returns mastership
  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lbus_en && !ack_s) |=> lbus_en);

  // R8: stall covers every pending or active handover
  assert_stall_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s || grant || !lbus_en) |-> stall);
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic ack_n,
  input  logic cyc_busy,
  output logic grant_n,
  output logic lbus_en,
  output logic stall
);
  localparam int SYNC_W = 2;

  logic              rst_sync_n;
  logic [SYNC_W-1:0] raw_in, sync_out;
  logic              req_s, ack_s, grant;

  arb_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_in = {~ack_n, ~req_n};

  arb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign req_s = sync_out[0];
  assign ack_s = sync_out[1];

  arb_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_s    (req_s),
    .ack_s    (ack_s),
    .cyc_busy (cyc_busy),
    .grant    (grant),
    .lbus_en  (lbus_en),
    .stall    (stall)
  );

  assign grant_n = ~grant;
endmodule

// File: tb/test_bus_handover_ctrl.sv
`timescale 1ns/1ps
module test_bus_handover_ctrl;
  localparam int S_IDLE = 0, S_WAIT = 1, S_GRANT = 2, S_EXT = 3;

  logic clk = 1'b0;
  logic rst_n, req_n, ack_n, cyc_busy;
  logic grant_n, lbus_en, stall;

  int checks = 0;
  int fails  = 0;

  int  m_st;
  bit  q1r, q2r, q1a, q2a;
  bit  cur_r, cur_a, cur_b;

  always #2 clk = ~clk;

  bus_handover_ctrl i_bus_handover_ctrl (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_n(ack_n),
    .cyc_busy(cyc_busy), .grant_n(grant_n), .lbus_en(lbus_en), .stall(stall)
  );

  function automatic int next_st(int st, bit rs, bit as, bit busy);
    case (st)
      S_IDLE:  return rs ? (busy ? S_WAIT : S_GRANT) : S_IDLE;
      S_WAIT:  return !rs ? S_IDLE : (!busy ? S_GRANT : S_WAIT);
      S_GRANT: return as ? S_EXT : (!rs ? S_IDLE : S_GRANT);
      default: return as ? S_EXT : S_IDLE;
    endcase
  endfunction

  function automatic bit exp_grant_n(int st); return !(st == S_GRANT); endfunction
  function automatic bit exp_lbus(int st);    return st != S_EXT;      endfunction
  function automatic bit exp_stall(int st, bit rs); return (st != S_IDLE) || rs; endfunction

  function automatic string tag_of(int st);
    case (st)
      S_IDLE:  return "R2";
      S_WAIT:  return "R3";
      S_GRANT: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag);
    bit eg, el, es;
    eg = exp_grant_n(m_st); el = exp_lbus(m_st); es = exp_stall(m_st, q2r);
    checks++;
    if (grant_n !== eg || lbus_en !== el || stall !== es) begin
      fails++;
      $display("FAIL %s: grant_n=%b lbus_en=%b stall=%b expected %b %b %b",
               tag, grant_n, lbus_en, stall, eg, el, es);
    end
  endtask

  task automatic step(bit r, bit a, bit b, string tag);
    req_n = ~r; ack_n = ~a; cyc_busy = b;
    cur_r = r; cur_a = a; cur_b = b;
    @(posedge clk);
    m_st = next_st(m_st, q2r, q2a, b);
    q2r = q1r; q1r = r; q2a = q1a; q1a = a;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit nr, na, nb;
    rst_n = 1'b0; req_n = 1'b1; ack_n = 1'b1; cyc_busy = 1'b0;
    m_st = S_IDLE; q1r = 0; q2r = 0; q1a = 0; q2a = 0;
    repeat (3) @(negedge clk);
    check("R9");
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, "R9");

    // R1 / R2: latency through the synchronizer, idle bus
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R2");
    // R5: acknowledge under grant
    repeat (3) step(1, 1, 0, "R5");
    // R6: request toggles while ownership is external
    step(0, 1, 0, "R6"); step(1, 1, 0, "R6"); step(0, 1, 0, "R6");
    step(0, 1, 0, "R6"); step(1, 1, 0, "R8");
    // R7: release acknowledge, request gone
    step(0, 0, 0, "R7"); step(0, 0, 0, "R7"); step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");

    // R3: long local cycle delays the grant
    step(0, 0, 1, "R3");
    repeat (6) step(1, 0, 1, "R3");
    repeat (3) step(1, 0, 0, "R3");
    // R4: withdraw while granted, no acknowledge
    repeat (4) step(0, 0, 0, "R4");

    // R4: withdraw while waiting for the cycle end
    repeat (4) step(1, 0, 1, "R4");
    repeat (4) step(0, 0, 1, "R4");
    step(0, 0, 0, "R4");
    // R4: one-cycle glitch on request
    step(1, 0, 0, "R4");
    repeat (4) step(0, 0, 0, "R4");

    // R7: acknowledge released with request still present
    repeat (3) step(1, 0, 0, "R7");
    repeat (3) step(1, 1, 0, "R7");
    repeat (4) step(1, 0, 0, "R7");
    repeat (4) step(0, 0, 0, "R7");

    // constrained random
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      if (!lbus_en)           nb = 0;
      else if (cur_b)         nb = ($urandom % 4) != 0;
      else if (!stall)        nb = ($urandom % 3) == 0;
      else                    nb = 0;
      if (cur_a)              na = ($urandom % 8) != 0;
      else if (!grant_n)      na = ($urandom % 2) == 0;
      else                    na = 0;
      nr = cur_r;
      if ((!cur_a && !na && !(q1a || q2a)) || !lbus_en)
        if (($urandom % 6) == 0) nr = !cur_r;
      step(nr, na, nb, tag_of(m_st));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule